// File: doc/BRIEF.md
# UART Transmit Holding Register with Line Status

This block forms the transmit half of a simple serial port. A CPU writes one character at a time into a single-entry holding register. Whenever the shift stage is idle, the held character moves into it and goes out on the serial line as a frame. The frame is a low start bit, the data bits least-significant first, and a high stop bit. Each bit lasts a fixed number of baud ticks, and the ticks come from an external rate generator.

Two status flags appear in a read-only status byte. The holding-empty flag sets at the moment a character leaves the holding register for the shift stage. It does not wait for the end of the transmission. The transmitter-idle flag is set only when neither stage holds a character. An interrupt request is raised when the holding register becomes free while the interrupt enable input is high. The request is dropped by a CPU write or by turning the enable off.

Top module: `uart_tx_hold`

## Requirements
- R1: The holding-empty flag (status bit 5) sets at the clock edge where the held character moves into the shift stage. When the shift stage is already idle, this happens one clock after the write.
- R2: A CPU write clears the holding-empty flag at the same clock edge that loads the holding register.
- R3: An interrupt request is pending after a transfer into the shift stage while the enable is high. It is also pending after the enable rises while the holding register is free.
- R4: The transmitter-idle flag (status bit 6) is 1 only while both the holding register and the shift stage are empty, and 0 while either holds a character.
- R5: Status bit 7 and bits 4 to 0 always read 0.
- R6: In reset and just after it, the status byte reads 0x60, the serial output is high and no interrupt is pending.
- R7: A frame is one low start bit, then 8 data bits sent LSB first, then one high stop bit. Each bit lasts 16 baud ticks.
- R8: A write while the holding register is full replaces the waiting character, and only the last one written is sent.
- R9: The interrupt request drops one clock after a CPU write, and one clock after the enable goes low.
- R10: A held character stays in the holding register while a frame is in progress, so the holding-empty flag remains 0 until that frame's stop bit completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU write strobe for the holding register |
| wr_data | input | 8 | CPU write data |
| baud_tick | input | 1 | One-clock pulse, 16 per bit time |
| irq_en | input | 1 | Holding-empty interrupt enable |
| ser_out | output | 1 | Serial transmit line, idle high |
| line_status | output | 8 | Status byte: bit 6 transmitter idle, bit 5 holding empty |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that baud_tick and wr_en are synchronous to the clock and carry no unknowns once reset is released. They also assume that irq_en is held low during reset, so that the no-interrupt reset state is meaningful. The bench keeps to these assumptions. It drives every input one nanosecond after a rising edge, and it produces the tick from a free-running divider as a single-clock pulse every third clock. It raises the enable only after reset has ended.

// File: rtl/uart_txh_pkg.sv
// Shared definitions for the UART transmit holding block.
// Assumes an 8-bit status byte whose flag positions are fixed for software.
package uart_txh_pkg;
    localparam int STAT_W       = 8;
    localparam int HOLD_MT_BIT  = 5;   // holding register free
    localparam int TX_IDLE_BIT  = 6;   // both stages free

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_t;
endpackage

// File: rtl/utx_hold_reg.sv
// One-entry holding register written by the CPU.
// Assumes wr_en and take are synchronous to clk. A write in the same cycle as
// take wins, so the register stays full with the new character.
module utx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Capture CPU data and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/utx_shifter.sv
// Frame serialiser: start bit, DATA_W data bits LSB first, stop bit.
// Assumes baud_tick is a one-clock pulse and load is only raised while idle.
module utx_shifter
    import uart_txh_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              ser_out
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int TCNT_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int BCNT_W  = $clog2(FRAME_W);
    localparam logic [TCNT_W-1:0] TICK_LAST = TCNT_W'(TICKS_PER_BIT - 1);
    localparam logic [BCNT_W-1:0] BIT_LAST  = BCNT_W'(FRAME_W - 1);

    sh_state_t          state;
    logic [FRAME_W-1:0] frame_q;
    logic [TCNT_W-1:0]  tick_cnt;
    logic [BCNT_W-1:0]  bit_cnt;

    // Load a framed character, then step one bit every TICKS_PER_BIT ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SH_IDLE;
            frame_q  <= '1;
            tick_cnt <= '0;
            bit_cnt  <= '0;
        end else if (load) begin
            state    <= SH_BUSY;
            frame_q  <= {1'b1, load_data, 1'b0};
            tick_cnt <= '0;
            bit_cnt  <= '0;
        end else if (state == SH_BUSY && baud_tick) begin
            if (tick_cnt == TICK_LAST) begin
                tick_cnt <= '0;
                frame_q  <= {1'b1, frame_q[FRAME_W-1:1]};
                if (bit_cnt == BIT_LAST) begin
                    state   <= SH_IDLE;
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // Drive the line from the frame LSB while busy, high otherwise.
    always_comb begin
        busy    = (state == SH_BUSY);
        ser_out = busy ? frame_q[0] : 1'b1;
    end
endmodule

// File: rtl/utx_status_irq.sv
// Status byte assembly and the holding-empty interrupt request.
// Assumes irq_en is low during reset. The request is a latched event: it is
// set by a transfer or by the enable rising while free, and cleared by a write
// or by the enable falling.
module utx_status_irq
    import uart_txh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full,
    input  logic              sh_busy,
    input  logic              wr_en,
    input  logic              transfer,
    input  logic              irq_en,
    output logic [STAT_W-1:0] line_status,
    output logic              irq
);
    logic en_q;

    // Track the enable and hold the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            irq  <= 1'b0;
        end else begin
            en_q <= irq_en;
            if (!irq_en || wr_en)
                irq <= 1'b0;
            else if (transfer || (!en_q && !hold_full))
                irq <= 1'b1;
        end
    end

    // Build the read-only status byte; unused bits stay zero.
    always_comb begin
        line_status              = '0;
        line_status[HOLD_MT_BIT] = !hold_full;
        line_status[TX_IDLE_BIT] = !hold_full && !sh_busy;
    end
endmodule

// File: rtl/uart_tx_hold.sv
// UART transmit side: holding register, serialiser and status/interrupt.
// Assumes baud_tick is a one-clock pulse at TICKS_PER_BIT times the bit rate.
module uart_tx_hold
    import uart_txh_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic              irq_en,
    output logic              ser_out,
    output logic [STAT_W-1:0] line_status,
    output logic              irq
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_busy;
    logic              transfer;

    // Move a held character whenever the shift stage is free.
    always_comb transfer = hold_full && !sh_busy;

    utx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (transfer),
        .full    (hold_full),
        .data    (hold_data)
    );

    utx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .load      (transfer),
        .load_data (hold_data),
        .busy      (sh_busy),
        .ser_out   (ser_out)
    );

    utx_status_irq u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_full   (hold_full),
        .sh_busy     (sh_busy),
        .wr_en       (wr_en),
        .transfer    (transfer),
        .irq_en      (irq_en),
        .line_status (line_status),
        .irq         (irq)
    );
endmodule

// File: rtl/uart_tx_hold_chk.sv
// Property checker for uart_tx_hold, attached by bind.
// Assumes inputs are free of unknowns once reset is released.
module uart_tx_hold_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       irq_en,
    input logic       ser_out,
    input logic [7:0] line_status,
    input logic       irq
);
    p_hmt_clr_on_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !line_status[5]);

    // R1: the flag only rises on a transfer, so the shift stage is busy then
    p_hmt_rise_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_status[5]) |-> !line_status[6]);

    p_idle_implies_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[6] |-> line_status[5]);

    p_idle_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[6] |-> ser_out);

    p_start_not_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_out) |-> !line_status[6]);

    p_irq_needs_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> line_status[5]);

    p_irq_drop_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    p_irq_drop_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq);
endmodule

bind uart_tx_hold uart_tx_hold_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .irq_en      (irq_en),
    .ser_out     (ser_out),
    .line_status (line_status),
    .irq         (irq)
);

// File: tb/test_uart_tx_hold.sv
// Self-checking bench for uart_tx_hold: a vector table walk followed by
// directed reset, overwrite and interrupt tests.
module test_uart_tx_hold;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       irq_en = 1'b0;
    logic       ser_out;
    logic [7:0] line_status;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;

    // {stimulus byte, expected received byte}
    localparam logic [15:0] VEC [6] = '{16'h5555, 16'hA3A3, 16'h0000,
                                       16'hFFFF, 16'h8181, 16'h3C3C};

    always #2.5 clk = ~clk;   // 200 MHz

    uart_tx_hold i_uart_tx_hold (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .baud_tick (baud_tick), .irq_en (irq_en), .ser_out (ser_out),
        .line_status (line_status), .irq (irq)
    );

    // Baud tick: one clock in three.
    initial begin
        int div = 0;
        forever begin
            @(posedge clk); #1;
            div = (div == 2) ? 0 : div + 1;
            baud_tick = (div == 0);
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [7:0] d);
        @(posedge clk); #1; wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(posedge clk); #1; irq_en = v;
        @(posedge clk); #1;
    endtask

    // Sample each bit at its middle by counting ticks from the start bit.
    task automatic rx_frame(output logic [7:0] b, output logic ok);
        int seen = 0;
        int k = 0;
        logic [9:0] f = '0;
        do @(negedge clk); while (ser_out !== 1'b0);
        while (k < 10) begin
            if (baud_tick) begin
                seen++;
                if (seen == 8 + 16 * k) begin
                    f[k] = ser_out;
                    k++;
                end
            end
            @(negedge clk);
        end
        b  = f[8:1];
        ok = (f[0] == 1'b0) && (f[9] == 1'b1);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (line_status[6] !== 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic ok;
        // Reset state: R6, R5
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R6 status in reset", line_status, 8'h60);
        chk("R6 line in reset", {7'd0, ser_out}, 8'h01);
        chk("R6 irq in reset", {7'd0, irq}, 8'h00);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk("R6 status after reset", line_status, 8'h60);
        chk("R5 reserved bits zero", line_status & 8'h9F, 8'h00);

        // Vector table walk: R1, R2, R4, R7
        for (int i = 0; i < 6; i++) begin
            cpu_write(VEC[i][15:8]);
            @(negedge clk);
            chk("R2 hold flag cleared by write", {7'd0, line_status[5]}, 8'h00);
            chk("R4 idle flag clear while held", {7'd0, line_status[6]}, 8'h00);
            @(negedge clk);
            chk("R1 hold flag set on transfer", {7'd0, line_status[5]}, 8'h01);
            chk("R4 idle flag clear while shifting", {7'd0, line_status[6]}, 8'h00);
            rx_frame(b, ok);
            chk("R7 frame data", b, VEC[i][7:0]);
            chk("R7 start and stop bits", {7'd0, ok}, 8'h01);
            wait_idle();
            chk("R4 idle status after frame", line_status, 8'h60);
            chk("R7 line high when idle", {7'd0, ser_out}, 8'h01);
        end

        // Overwrite while full and hold during transmission: R8, R10
        cpu_write(8'h12);
        cpu_write(8'h34);
        cpu_write(8'h56);
        @(negedge clk);
        chk("R10 hold flag low while waiting", {7'd0, line_status[5]}, 8'h00);
        rx_frame(b, ok);
        chk("R7 first frame data", b, 8'h12);
        chk("R10 still held near end of frame", line_status, 8'h00);
        rx_frame(b, ok);
        chk("R8 last written character sent", b, 8'h56);
        chk("R8 framing of replacement", {7'd0, ok}, 8'h01);
        wait_idle();
        chk("R8 nothing further queued", line_status, 8'h60);

        // Interrupt behaviour: R3, R9
        set_en(1'b1);
        @(negedge clk);
        chk("R3 irq on enable while free", {7'd0, irq}, 8'h01);
        set_en(1'b0);
        @(negedge clk);
        chk("R9 irq drops with enable", {7'd0, irq}, 8'h00);
        set_en(1'b1);
        cpu_write(8'hC5);
        @(negedge clk);
        chk("R9 irq drops on write", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R3 irq on transfer", {7'd0, irq}, 8'h01);
        cpu_write(8'h7E);
        repeat (20) @(negedge clk);
        chk("R9 irq stays low while held", {7'd0, irq}, 8'h00);
        rx_frame(b, ok);
        chk("R7 interrupt test frame", b, 8'hC5);
        do @(negedge clk); while (line_status[5] !== 1'b1);
        chk("R3 irq after second transfer", {7'd0, irq}, 8'h01);
        chk("R4 not idle while shifting", {7'd0, line_status[6]}, 8'h00);
        set_en(1'b0);
        @(negedge clk);
        chk("R9 irq drops on disable", {7'd0, irq}, 8'h00);
        wait_idle();
        chk("R5 status after all traffic", line_status, 8'h60);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule